// File: doc/BRIEF.md
# Controller FSM with Unreachable-State Injection

This block is a small controller state machine with a test path in front of its state register. In normal use it is an ordinary sequencer: primary inputs and a status input from the datapath steer the next-state logic, and the state drives a set of control outputs. For test, a generator holds an ordered list of state codes that the sequencer can never reach from reset. A mode pin switches the state register's input from the next-state logic to that generator. A separate hold pin freezes the register, so a test program can park the machine in any state for as long as it needs.

The next-state and output logic is an unchanged combinational block. Injected codes feed that same logic, so any pattern that needs an unreachable present state can be applied by loading the code and then giving one functional clock. The current state is always driven out on its own port so a tester can see it. With both test pins low the block is the plain sequencer.

Top module: `inj_fsm_top`

## Requirements
- R1: A synchronous active-high reset puts the state at code 0 (idle) and returns the generator to the first entry of its list.
- R2: With both test pins low, the state follows the sequencer: idle(0) goes to load(1) when primary input bit 0 is 1, else stays; load(1) goes to run(2); run(2) goes to idle when primary input bit 1 is 1, else to done(3) when the status input is 1, else stays; done(3) goes to wrap(4); wrap(4) goes to idle.
- R3: With the inject pin at 1 and the hold pin at 0, each clock loads the current generator entry. Entries come in list order and wrap after the last one. The default list is 6, 5, 7.
- R4: With the hold pin at 1, the state keeps its value whatever the inject pin, primary inputs and status input do, and the generator does not advance.
- R5: The generator advances only on a clock where it is selected and the register loads. Functional loads leave it at its current entry.
- R6: From an unreachable code (5, 6 or 7), one functional clock with test pins low moves the state to the code equal to the 2-bit primary input.
- R7: Control outputs: bit 0 is 1 in load, bit 1 is 1 in run, bit 2 is 1 in done or wrap, and bit 3 is the XOR of the three state bits and the status input.
- R8: The state output port always shows the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pri_in | input | PI_W (2) | Primary inputs to the sequencer |
| sts_in | input | SI_W (1) | Status input from the datapath |
| tst_inject | input | 1 | Selects the generator as the state register source |
| tst_hold | input | 1 | 1 freezes the state register |
| ctl_out | output | CO_W (4) | Control outputs |
| st_obs | output | ST_W (3) | Current state, observable |

## Verification
The sequencer is driven along its full loop, through the abort branch and through the wait-in-run case. These runs separate correct functional next-state decoding from a mux that leaks generator codes. Injection is run for more cycles than the list is long, which exposes wrong entry order or wrong wrap. Holds are applied both with the inject pin set and with the functional inputs moving, which separates a true freeze from a load of either source. Each listed code is parked, held, then given one functional clock with a different primary input pattern. This shows that injected states really reach the unchanged next-state and output logic, and that functional clocks leave the generator position alone.

// File: rtl/inj_fsm_pkg.sv
package inj_fsm_pkg;

   localparam int EX_ST_W = 3;
   localparam int EX_PI_W = 2;
   localparam int EX_SI_W = 1;
   localparam int EX_CO_W = 4;

   localparam logic [EX_ST_W-1:0] S_IDLE = 3'd0;
   localparam logic [EX_ST_W-1:0] S_LOAD = 3'd1;
   localparam logic [EX_ST_W-1:0] S_RUN  = 3'd2;
   localparam logic [EX_ST_W-1:0] S_DONE = 3'd3;
   localparam logic [EX_ST_W-1:0] S_WRAP = 3'd4;

   // true for codes the example sequencer reaches from reset
   function automatic bit ex_reachable(input int code);
      return (code >= 0) && (code <= 4);
   endfunction

endpackage

// File: rtl/inj_fsm_comb.sv
module inj_fsm_comb
   import inj_fsm_pkg::*;
#(
   parameter int ST_W = 3,
   parameter int PI_W = 2,
   parameter int SI_W = 1,
   parameter int CO_W = 4
) (
   input  logic [ST_W-1:0] cur,
   input  logic [PI_W-1:0] pi,
   input  logic [SI_W-1:0] si,
   output logic [ST_W-1:0] nxt,
   output logic [CO_W-1:0] co
);

   initial begin
      assert (ST_W == EX_ST_W && PI_W == EX_PI_W && SI_W == EX_SI_W && CO_W == EX_CO_W)
         else $error("inj_fsm_comb: widths must match the example sequencer");
   end

   // original next-state logic, left as designed
   always_comb begin
      case (cur)
         S_IDLE:  nxt = pi[0] ? S_LOAD : S_IDLE;
         S_LOAD:  nxt = S_RUN;
         S_RUN:   nxt = pi[1] ? S_IDLE : (si[0] ? S_DONE : S_RUN);
         S_DONE:  nxt = S_WRAP;
         S_WRAP:  nxt = S_IDLE;
         default: nxt = ST_W'(pi);
      endcase
   end

   // original output logic
   always_comb begin
      co    = '0;
      co[0] = (cur == S_LOAD);
      co[1] = (cur == S_RUN);
      co[2] = (cur == S_DONE) || (cur == S_WRAP);
      co[3] = ^{cur, si};
   end

endmodule

// File: rtl/inj_fsm_isg.sv
module inj_fsm_isg
   import inj_fsm_pkg::*;
#(
   parameter int                        ST_W     = 3,
   parameter int                        NUM_INV  = 3,
   parameter logic [NUM_INV*ST_W-1:0]   INV_LIST = {3'd7, 3'd5, 3'd6}
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            step,
   output logic [ST_W-1:0] code
);

   localparam int IDX_W = (NUM_INV > 1) ? $clog2(NUM_INV) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_INV - 1);

   logic [ST_W-1:0]  tbl [NUM_INV];
   logic [IDX_W-1:0] idx_q;

   initial begin
      assert (NUM_INV >= 1) else $error("inj_fsm_isg: list must not be empty");
   end

   for (genvar g = 0; g < NUM_INV; g++) begin : g_entry
      assign tbl[g] = INV_LIST[g*ST_W +: ST_W];
      initial begin
         assert (!ex_reachable(int'(INV_LIST[g*ST_W +: ST_W])))
            else $error("inj_fsm_isg: entry %0d is a reachable state", g);
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         idx_q <= '0;
      else if (step)
         idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
   end

   assign code = tbl[idx_q];

   a_r5_idx_frozen: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(idx_q));
   a_r1_idx_reset: assert property (@(posedge clk)
      rst |=> (idx_q == '0));
   always_comb begin
      if (!rst) a_r3_idx_range: assert (int'(idx_q) < NUM_INV);
   end

endmodule

// File: rtl/inj_fsm_sreg.sv
module inj_fsm_sreg #(
   parameter int              ST_W     = 3,
   parameter logic [ST_W-1:0] RESET_ST = '0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            inject,
   input  logic            hold,
   input  logic [ST_W-1:0] func_nxt,
   input  logic [ST_W-1:0] inv_code,
   output logic [ST_W-1:0] state_q
);

   logic [ST_W-1:0] d_sel;

   assign d_sel = inject ? inv_code : func_nxt;

   always_ff @(posedge clk) begin
      if (rst)
         state_q <= RESET_ST;
      else if (!hold)
         state_q <= d_sel;
   end

   a_r4_hold_keeps: assert property (@(posedge clk) disable iff (rst)
      hold |=> $stable(state_q));
   a_r3_inject_loads: assert property (@(posedge clk) disable iff (rst)
      (inject && !hold) |=> (state_q == $past(inv_code)));
   a_r2_func_loads: assert property (@(posedge clk) disable iff (rst)
      (!inject && !hold) |=> (state_q == $past(func_nxt)));
   a_r1_state_reset: assert property (@(posedge clk)
      rst |=> (state_q == RESET_ST));

endmodule

// File: rtl/inj_fsm_top.sv
module inj_fsm_top
   import inj_fsm_pkg::*;
#(
   parameter int                      ST_W     = 3,
   parameter int                      PI_W     = 2,
   parameter int                      SI_W     = 1,
   parameter int                      CO_W     = 4,
   parameter int                      NUM_INV  = 3,
   parameter logic [NUM_INV*ST_W-1:0] INV_LIST = {3'd7, 3'd5, 3'd6}
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [PI_W-1:0] pri_in,
   input  logic [SI_W-1:0] sts_in,
   input  logic            tst_inject,
   input  logic            tst_hold,
   output logic [CO_W-1:0] ctl_out,
   output logic [ST_W-1:0] st_obs
);

   logic [ST_W-1:0] cur_st;
   logic [ST_W-1:0] nxt_st;
   logic [ST_W-1:0] inv_code;
   logic            gen_step;

   assign gen_step = tst_inject && !tst_hold;

   inj_fsm_comb #(.ST_W(ST_W), .PI_W(PI_W), .SI_W(SI_W), .CO_W(CO_W)) u_comb (
      .cur (cur_st),
      .pi  (pri_in),
      .si  (sts_in),
      .nxt (nxt_st),
      .co  (ctl_out)
   );

   inj_fsm_isg #(.ST_W(ST_W), .NUM_INV(NUM_INV), .INV_LIST(INV_LIST)) u_isg (
      .clk  (clk),
      .rst  (rst),
      .step (gen_step),
      .code (inv_code)
   );

   inj_fsm_sreg #(.ST_W(ST_W), .RESET_ST(S_IDLE)) u_sreg (
      .clk      (clk),
      .rst      (rst),
      .inject   (tst_inject),
      .hold     (tst_hold),
      .func_nxt (nxt_st),
      .inv_code (inv_code),
      .state_q  (cur_st)
   );

   // R8: observed state is the register itself
   assign st_obs = cur_st;

endmodule

// File: tb/inj_fsm_top_tb.sv
module inj_fsm_top_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] pri_in = '0;
   logic [0:0] sts_in = '0;
   logic       tst_inject = 1'b0;
   logic       tst_hold = 1'b0;
   logic [3:0] ctl_out;
   logic [2:0] st_obs;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // default list order from R3
   logic [2:0] inv_ref [3] = '{3'd6, 3'd5, 3'd7};

   always #4 clk = ~clk;

   inj_fsm_top u_dut (
      .clk(clk), .rst(rst), .pri_in(pri_in), .sts_in(sts_in),
      .tst_inject(tst_inject), .tst_hold(tst_hold),
      .ctl_out(ctl_out), .st_obs(st_obs)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int co_ref(input logic [2:0] s, input logic si);
      logic [3:0] c;
      c[0] = (s == 3'd1);
      c[1] = (s == 3'd2);
      c[2] = (s == 3'd3) || (s == 3'd4);
      c[3] = ^{s, si};
      return int'(c);
   endfunction

   task automatic drive(input logic [1:0] p, input logic s, input logic inj, input logic hd);
      pri_in = p; sts_in = s; tst_inject = inj; tst_hold = hd;
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic do_reset();
      drive(2'b00, 1'b0, 1'b0, 1'b0);
      rst = 1'b1; tick(); rst = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 reset state", st_obs, 0);
      chk("R7 idle outputs", ctl_out, co_ref(3'd0, 1'b0));
   endtask

   task automatic t_functional();
      do_reset();
      drive(2'b00, 1'b0, 1'b0, 1'b0); tick(); chk("R2 idle stays", st_obs, 0);
      drive(2'b01, 1'b0, 1'b0, 1'b0); tick(); chk("R2 idle to load", st_obs, 1);
      chk("R7 load strobe", ctl_out, co_ref(3'd1, 1'b0));
      drive(2'b00, 1'b0, 1'b0, 1'b0); tick(); chk("R2 load to run", st_obs, 2);
      chk("R7 run si0", ctl_out, co_ref(3'd2, 1'b0));
      tick(); chk("R2 run waits", st_obs, 2);
      drive(2'b00, 1'b1, 1'b0, 1'b0);
      #1 chk("R7 run si1", ctl_out, co_ref(3'd2, 1'b1));
      tick(); chk("R2 run to done", st_obs, 3);
      drive(2'b00, 1'b0, 1'b0, 1'b0); tick(); chk("R2 done to wrap", st_obs, 4);
      chk("R7 wrap outputs", ctl_out, co_ref(3'd4, 1'b0));
      tick(); chk("R2 wrap to idle", st_obs, 0);
      drive(2'b01, 1'b0, 1'b0, 1'b0); tick();
      drive(2'b00, 1'b0, 1'b0, 1'b0); tick();
      drive(2'b10, 1'b1, 1'b0, 1'b0); tick(); chk("R2 abort wins", st_obs, 0);
      chk("R8 observed equals idle", st_obs, 0);
   endtask

   task automatic t_inject_order();
      do_reset();
      drive(2'b00, 1'b0, 1'b1, 1'b0);
      for (int k = 0; k < 5; k++) begin
         tick();
         chk("R3 inject order", st_obs, int'(inv_ref[k % 3]));
      end
   endtask

   task automatic t_hold();
      do_reset();
      drive(2'b00, 1'b0, 1'b1, 1'b0); tick();
      chk("R1 generator at first entry", st_obs, 6);
      for (int k = 0; k < 3; k++) begin
         drive(2'(k + 1), 1'(k), 1'b1, 1'b1); tick();
         chk("R4 hold with inject", st_obs, 6);
      end
      drive(2'b01, 1'b1, 1'b0, 1'b1); tick();
      chk("R4 hold with function", st_obs, 6);
      drive(2'b00, 1'b0, 1'b1, 1'b0); tick();
      chk("R4 generator not advanced", st_obs, 5);
      // reset returns generator to its first entry
      do_reset();
      drive(2'b00, 1'b0, 1'b1, 1'b0); tick();
      chk("R1 generator rewound", st_obs, 6);
   endtask

   task automatic t_func_no_step();
      do_reset();
      drive(2'b00, 1'b0, 1'b1, 1'b0); tick();
      chk("R5 first inject", st_obs, 6);
      drive(2'b01, 1'b0, 1'b0, 1'b0); tick();
      chk("R5 functional from 6", st_obs, 1);
      drive(2'b00, 1'b0, 1'b0, 1'b0); tick(); tick(); tick();
      drive(2'b00, 1'b0, 1'b1, 1'b0); tick();
      chk("R5 next entry after functional loads", st_obs, 5);
   endtask

   task automatic t_use_invalid();
      for (int k = 0; k < 3; k++) begin
         do_reset();
         drive(2'b00, 1'b0, 1'b1, 1'b0);
         for (int j = 0; j <= k; j++) tick();
         chk("R3 parked entry", st_obs, int'(inv_ref[k]));
         drive(2'b11, 1'b1, 1'b0, 1'b1); tick(); tick();
         chk("R4 parked held", st_obs, int'(inv_ref[k]));
         chk("R7 invalid outputs", ctl_out, co_ref(inv_ref[k], 1'b1));
         drive(2'(k + 1), 1'b0, 1'b0, 1'b0);
         #1 chk("R7 invalid outputs si0", ctl_out, co_ref(inv_ref[k], 1'b0));
         tick();
         chk("R6 functional step from invalid", st_obs, k + 1);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_functional();
      t_inject_order();
      t_hold();
      t_func_no_step();
      t_use_invalid();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule